// File: doc/BRIEF.md
# Latched Event Status Reporting Unit

This block holds the status-reporting state of an instrument's remote-control interface. Four 8-bit event registers collect one-cycle event pulses: standard events, communication errors, PLL lock events and instrument events. A bit set by a pulse stays set until software reads that register, which returns its contents and clears it, or until a clear-status strobe clears all four at once. The instrument-reset and device-clear strobes leave the event bits as they are.

Each event register has an 8-bit enable mask. When an event register has a bit that is both set and enabled, its summary bit in the status byte is set. The status byte also carries a live copy of the output-buffer-not-empty flag. A service-request enable mask selects which status byte bits drive the master summary bit and the service-request output. A single register-select port serves both reads and writes. Command parsing, the bus transport and the output buffer are outside this block.

Top module: `status_report_unit`

## Requirements
- R1: A 1 on any bit of an event input sets the matching event register bit at the next clock edge. The bit then stays set while its input is 0 and until it is cleared.
- R2: When rd_en_i is high and rd_sel_i is 0 (standard), 1 (communication), 2 (lock) or 3 (instrument), rd_data_o returns that event register's current contents in the same cycle, and the register is cleared at the next edge.
- R3: If an event pulse arrives in the same cycle as a clearing read or a cls_i strobe, the pulsed bits are set after the edge. No event is lost.
- R4: cls_i clears all four event registers at the next edge. It leaves the enable masks and the service-request mask unchanged.
- R5: inst_rst_i and dev_clr_i change no register: no event bit, no enable mask and no service-request mask.
- R6: A write with wr_en_i high loads all eight bits of wr_data_i into an enable mask: rd_sel code 4 standard, 5 communication, 6 lock, 7 instrument. Code 9 loads the service-request mask. Every mask reads back at its own code. A read does not change a mask.
- R7: stb_o bit 0 is the OR of (instrument event AND its enable). Bit 1 is the same for lock, bit 2 for communication, and bit 5 for standard.
- R8: stb_o bit 4 follows buf_ne_i in the same cycle. Bits 3 and 7 are always 0.
- R9: stb_o bit 6 is 1 exactly when some stb_o bit in positions 0–5 is set together with the same bit of the service-request mask. Mask bit 6 is ignored. srq_o always equals stb_o bit 6.
- R10: A read with rd_sel_i = 8 returns stb_o. It clears no event register.
- R11: rst_ni low asynchronously clears all event registers, enable masks and the service-request mask to 0.
- R12: A read at codes 10–15 returns 0. A write at any code other than 4–7 and 9 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| evt_std_i | input | 8 | Standard event pulses |
| evt_comm_i | input | 8 | Communication error event pulses |
| evt_lock_i | input | 8 | PLL lock event pulses |
| evt_inst_i | input | 8 | Instrument event pulses |
| rd_en_i | input | 1 | Read strobe |
| rd_sel_i | input | 4 | Register code for reads and writes |
| rd_data_o | output | 8 | Read data for the selected register |
| wr_en_i | input | 1 | Write strobe for the masks |
| wr_data_i | input | 8 | Mask write data |
| cls_i | input | 1 | Clear-status strobe |
| inst_rst_i | input | 1 | Instrument-reset strobe (no effect on registers) |
| dev_clr_i | input | 1 | Device-clear strobe (no effect on registers) |
| buf_ne_i | input | 1 | Output buffer not empty |
| stb_o | output | 8 | Status byte |
| srq_o | output | 1 | Service request |

## Verification
Directed phases come first. One pulses single events and waits, which separates sticky bits from level-following ones. One places a pulse in the same cycle as a destructive read or a clear-status strobe, which separates event-wins ordering from clear-wins ordering. Another reads the status byte and the masks repeatedly, which separates non-destructive reads from destructive ones. Walking mask patterns then show that each summary bit lands in its own position, that mask bit 6 of the service-request mask does not feed back, and that the reset strobes and writes to unwritable codes leave state intact. A long random mix of every input follows, compared each cycle against a behavioural model, to cover overlapping reads, writes and strobes.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int DATA_W  = 8;
  localparam int NUM_EVT = 4;
  localparam int SEL_W   = 4;

  // event register index order: std, comm, lock, inst
  localparam int EV_STD  = 0;
  localparam int EV_COMM = 1;
  localparam int EV_LOCK = 2;
  localparam int EV_INST = 3;

  localparam int BIT_MAV = 4;
  localparam int BIT_MSS = 6;

  typedef enum logic [SEL_W-1:0] {
    SEL_EV_STD  = 4'd0,
    SEL_EV_COMM = 4'd1,
    SEL_EV_LOCK = 4'd2,
    SEL_EV_INST = 4'd3,
    SEL_EN_STD  = 4'd4,
    SEL_EN_COMM = 4'd5,
    SEL_EN_LOCK = 4'd6,
    SEL_EN_INST = 4'd7,
    SEL_STB     = 4'd8,
    SEL_SRE     = 4'd9
  } reg_sel_e;

  localparam int SEL_EN_BASE = 4;

  // status byte position of each event register summary
  function automatic int sum_pos(input int idx);
    case (idx)
      EV_STD:  return 5;
      EV_COMM: return 2;
      EV_LOCK: return 1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/status_sticky_reg.sv
module status_sticky_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  // new events override a same-cycle clear
  always_comb begin
    q_d = clr_i ? '0 : q_o;
    q_d = q_d | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/status_mask_reg.sv
module status_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/status_byte_gen.sv
module status_byte_gen
  import status_pkg::*;
(
  input  logic [NUM_EVT-1:0][DATA_W-1:0] ev_i,
  input  logic [NUM_EVT-1:0][DATA_W-1:0] en_i,
  input  logic [DATA_W-1:0]              sre_i,
  input  logic                           buf_ne_i,
  output logic [DATA_W-1:0]              stb_o,
  output logic                           srq_o
);
  localparam logic [DATA_W-1:0] MSS_MASK = DATA_W'(1) << BIT_MSS;

  logic [NUM_EVT-1:0] sum;
  logic [DATA_W-1:0]  base;
  logic               mss;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_sum
    assign sum[i] = |(ev_i[i] & en_i[i]);
  end

  always_comb begin
    base = '0;
    for (int i = 0; i < NUM_EVT; i++) base[sum_pos(i)] = sum[i];
    base[BIT_MAV] = buf_ne_i;
  end

  // mask bit 6 excluded so the master bit never feeds itself
  assign mss   = |(base & sre_i & ~MSS_MASK);
  assign stb_o = base | (mss ? MSS_MASK : '0);
  assign srq_o = mss;
endmodule

// File: rtl/status_report_unit.sv
module status_report_unit
  import status_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       evt_std_i,
  input  logic [7:0]       evt_comm_i,
  input  logic [7:0]       evt_lock_i,
  input  logic [7:0]       evt_inst_i,
  input  logic             rd_en_i,
  input  logic [3:0]       rd_sel_i,
  output logic [7:0]       rd_data_o,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic             cls_i,
  input  logic             inst_rst_i,
  input  logic             dev_clr_i,
  input  logic             buf_ne_i,
  output logic [7:0]       stb_o,
  output logic             srq_o
);
  logic [NUM_EVT-1:0][DATA_W-1:0] evt_all;
  logic [NUM_EVT-1:0][DATA_W-1:0] ev_q;
  logic [NUM_EVT-1:0][DATA_W-1:0] en_q;
  logic [DATA_W-1:0]              sre_q;
  logic [NUM_EVT-1:0]             ev_clr;
  logic [NUM_EVT-1:0]             en_we;
  logic                           sre_we;

  always_comb begin
    evt_all[EV_STD]  = evt_std_i;
    evt_all[EV_COMM] = evt_comm_i;
    evt_all[EV_LOCK] = evt_lock_i;
    evt_all[EV_INST] = evt_inst_i;
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_reg
    assign ev_clr[i] = cls_i | (rd_en_i & (rd_sel_i == SEL_W'(i)));
    assign en_we[i]  = wr_en_i & (rd_sel_i == SEL_W'(SEL_EN_BASE + i));

    status_sticky_reg #(.W(DATA_W)) u_ev (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (evt_all[i]),
      .clr_i (ev_clr[i]),
      .q_o   (ev_q[i])
    );

    status_mask_reg #(.W(DATA_W)) u_en (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (en_we[i]),
      .d_i   (wr_data_i),
      .q_o   (en_q[i])
    );
  end

  assign sre_we = wr_en_i & (rd_sel_i == SEL_SRE);

  status_mask_reg #(.W(DATA_W)) u_sre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (sre_we),
    .d_i   (wr_data_i),
    .q_o   (sre_q)
  );

  status_byte_gen u_stb (
    .ev_i    (ev_q),
    .en_i    (en_q),
    .sre_i   (sre_q),
    .buf_ne_i(buf_ne_i),
    .stb_o   (stb_o),
    .srq_o   (srq_o)
  );

  always_comb begin
    unique case (rd_sel_i)
      SEL_EV_STD:  rd_data_o = ev_q[EV_STD];
      SEL_EV_COMM: rd_data_o = ev_q[EV_COMM];
      SEL_EV_LOCK: rd_data_o = ev_q[EV_LOCK];
      SEL_EV_INST: rd_data_o = ev_q[EV_INST];
      SEL_EN_STD:  rd_data_o = en_q[EV_STD];
      SEL_EN_COMM: rd_data_o = en_q[EV_COMM];
      SEL_EN_LOCK: rd_data_o = en_q[EV_LOCK];
      SEL_EN_INST: rd_data_o = en_q[EV_INST];
      SEL_STB:     rd_data_o = stb_o;
      SEL_SRE:     rd_data_o = sre_q;
      default:     rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/status_report_chk.sv
module status_report_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] evt_all,
  input logic [31:0] ev_q,
  input logic [31:0] en_q,
  input logic [7:0]  sre_q,
  input logic        rd_en_i,
  input logic [3:0]  rd_sel_i,
  input logic        wr_en_i,
  input logic        cls_i,
  input logic        inst_rst_i,
  input logic        dev_clr_i,
  input logic        buf_ne_i,
  input logic [7:0]  stb_o,
  input logic        srq_o
);
  assert_evt_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_all != '0) |=> ((ev_q & $past(evt_all)) == $past(evt_all)));

  assert_evt_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel_i < 4'd4 && evt_all != '0) |=> ((ev_q & $past(evt_all)) == $past(evt_all)));

  assert_cls_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cls_i |=> ((ev_q & ~$past(evt_all)) == '0));

  assert_strobes_inert_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((inst_rst_i || dev_clr_i) && !cls_i && !rd_en_i && !wr_en_i && evt_all == '0)
      |=> ($stable(ev_q) && $stable(en_q) && $stable(sre_q)));

  assert_masks_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(en_q) && $stable(sre_q)));

  assert_fixed_bits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_o[3] == 1'b0) && (stb_o[7] == 1'b0) && (stb_o[4] == buf_ne_i));

  assert_srq_tracks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srq_o == stb_o[6]);

  assert_stb_read_keeps_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel_i == 4'd8 && !cls_i && evt_all == '0) |=> $stable(ev_q));
endmodule

bind status_report_unit status_report_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .evt_all   (evt_all),
  .ev_q      (ev_q),
  .en_q      (en_q),
  .sre_q     (sre_q),
  .rd_en_i   (rd_en_i),
  .rd_sel_i  (rd_sel_i),
  .wr_en_i   (wr_en_i),
  .cls_i     (cls_i),
  .inst_rst_i(inst_rst_i),
  .dev_clr_i (dev_clr_i),
  .buf_ne_i  (buf_ne_i),
  .stb_o     (stb_o),
  .srq_o     (srq_o)
);

// File: tb/status_report_unit_bench.sv
`timescale 1ns/1ps
module status_report_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt [4];
  logic       rd_en = 1'b0;
  logic [3:0] rd_sel = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cls = 1'b0, inst_rst = 1'b0, dev_clr = 1'b0, buf_ne = 1'b0;
  logic [7:0] rd_data, stb;
  logic       srq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string phase = "R11";

  // behavioural model state: index 0 std, 1 comm, 2 lock, 3 inst
  int m_ev [4];
  int m_en [4];
  int m_sre;

  always #2.5 clk = ~clk;

  status_report_unit u_status_report_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_std_i(evt[0]), .evt_comm_i(evt[1]), .evt_lock_i(evt[2]), .evt_inst_i(evt[3]),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .cls_i(cls), .inst_rst_i(inst_rst), .dev_clr_i(dev_clr),
    .buf_ne_i(buf_ne), .stb_o(stb), .srq_o(srq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_ev[i] = 0; m_en[i] = 0; end
      m_sre = 0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (cls || (rd_en && rd_sel == 4'(i))) m_ev[i] = 0;
        m_ev[i] = m_ev[i] | int'(evt[i]);
        if (wr_en && rd_sel == 4'(i + 4)) m_en[i] = int'(wr_data);
      end
      if (wr_en && rd_sel == 4'd9) m_sre = int'(wr_data);
    end
  end

  function automatic int model_stb();
    int s = 0;
    if ((m_ev[3] & m_en[3]) != 0) s += 1;
    if ((m_ev[2] & m_en[2]) != 0) s += 2;
    if ((m_ev[1] & m_en[1]) != 0) s += 4;
    if (buf_ne) s += 16;
    if ((m_ev[0] & m_en[0]) != 0) s += 32;
    if ((s & m_sre & 'hBF) != 0) s += 64;
    return s;
  endfunction

  function automatic int model_rd();
    int sel = int'(rd_sel);
    if (sel < 4) return m_ev[sel];
    if (sel < 8) return m_en[sel - 4];
    if (sel == 8) return model_stb();
    if (sel == 9) return m_sre;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s (phase %s) t=%0t actual=%0h expected=%0h", req, phase, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    int e = model_stb();
    int sel = int'(rd_sel);
    string rtag;
    check("R7", int'(stb) & 'h27, e & 'h27);
    check("R8", int'(stb) & 'h98, e & 'h98);
    check("R9", int'(stb) & 'h40, e & 'h40);
    check("R9", int'(srq), (e >> 6) & 1);
    if (sel < 4)       rtag = "R2";
    else if (sel == 8) rtag = "R10";
    else if (sel > 9)  rtag = "R12";
    else               rtag = "R6";
    check(rtag, int'(rd_data), model_rd());
  endtask

  task automatic idle_inputs();
    for (int i = 0; i < 4; i++) evt[i] = '0;
    rd_en = 0; wr_en = 0; cls = 0; inst_rst = 0; dev_clr = 0;
  endtask

  // one cycle: inputs set after a falling edge, outputs compared before the rising edge
  task automatic step();
    #1 compare_all();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_write(int sel, int val);
    rd_sel = 4'(sel); wr_en = 1; wr_data = 8'(val); step();
  endtask

  task automatic do_read(int sel);
    rd_sel = 4'(sel); rd_en = 1; step();
  endtask

  task automatic read_all();
    for (int s = 0; s < 16; s++) begin
      rd_sel = 4'(s); rd_en = (s >= 4); step();
    end
  endtask

  initial begin
    #900000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    @(negedge clk); @(negedge clk);
    // R11: reset state, event pulses held off while in reset
    phase = "R11";
    evt[0] = 8'hFF; #1 compare_all();
    check("R11", int'(stb), 0);
    idle_inputs();
    rst_n = 1;
    @(negedge clk);
    read_all();

    phase = "R1";
    evt[2] = 8'h08; step();
    for (int k = 0; k < 4; k++) step();
    do_read(2);            // returns 08 then clears
    do_read(2);            // now zero
    evt[3] = 8'h41; step();
    evt[3] = 8'h02; step();
    do_read(3);

    phase = "R3";
    evt[0] = 8'h80; step();
    rd_sel = 4'd0; rd_en = 1; evt[0] = 8'h01; step();
    do_read(0);            // 01 survived the clearing read
    evt[1] = 8'h10; step();
    cls = 1; evt[1] = 8'h04; evt[2] = 8'h20; step();
    do_read(1); do_read(2);

    phase = "R4";
    do_write(4, 'hFF); do_write(5, 'h0F); do_write(6, 'hF0); do_write(7, 'h3C); do_write(9, 'h27);
    for (int i = 0; i < 4; i++) evt[i] = 8'hFF;
    step();
    cls = 1; step();
    read_all();

    phase = "R5";
    evt[0] = 8'h11; evt[1] = 8'h22; evt[2] = 8'h44; evt[3] = 8'h88; step();
    inst_rst = 1; step();
    dev_clr = 1; step();
    inst_rst = 1; dev_clr = 1; step();
    read_all();

    phase = "R6";
    do_write(4, 'hA5); do_write(9, 'h5A);
    for (int k = 0; k < 3; k++) begin do_read(4); do_read(9); end
    do_write(4, 'h00);

    phase = "R7";
    do_write(9, 'h00);
    for (int i = 0; i < 4; i++) begin
      do_write(4 + i, 'h01 << i);
      evt[i] = 8'(1 << i); step();
      step();
      do_write(4 + i, 0);
      step();
      do_write(4 + i, 'hFF);
    end

    phase = "R9";
    for (int b = 0; b < 8; b++) begin
      do_write(9, 1 << b); step();
    end
    evt[0] = '0; do_write(9, 'h40); step();   // bit 6 of the mask alone requests nothing
    do_write(9, 'hFF); step();

    phase = "R8";
    for (int k = 0; k < 6; k++) begin buf_ne = k[0]; do_write(9, k[1] ? 'h10 : 'h00); end
    buf_ne = 0;

    phase = "R10";
    evt[3] = 8'h55; step();
    for (int k = 0; k < 4; k++) do_read(8);
    do_read(3);

    phase = "R12";
    evt[0] = 8'h0F; evt[1] = 8'hF0; step();
    for (int s = 0; s < 16; s++)
      if (!(s >= 4 && s <= 7) && s != 9) do_write(s, 'hC3);
    read_all();

    phase = "R11";
    do_write(5, 'h77);
    #1 rst_n = 0;
    #1 check("R11", int'(stb), 0);
    @(negedge clk); rst_n = 1;
    read_all();

    phase = "R2";
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < 4; i++) evt[i] = ($urandom_range(0, 5) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
      rd_sel  = 4'($urandom_range(0, 15));
      rd_en   = ($urandom_range(0, 2) == 0);
      wr_en   = ($urandom_range(0, 4) == 0);
      wr_data = 8'($urandom);
      cls     = ($urandom_range(0, 30) == 0);
      inst_rst = ($urandom_range(0, 20) == 0);
      dev_clr  = ($urandom_range(0, 20) == 0);
      buf_ne   = ($urandom_range(0, 1) == 1);
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule